// File: doc/BRIEF.md
# Double to Int32 Truncating Converter

This block turns a 64-bit IEEE-754 double-precision bit pattern into a 32-bit signed integer in the way a JavaScript engine applies ToInt32. The value is first truncated toward zero. The integer that results is then reduced modulo 2^32 and returned as a two's-complement word. It does not saturate. Next to the integer the block returns a four-bit condition word. Its only active bit tells the caller that the conversion was exact and in range, so compiled code can skip its slow fallback path. An exception pulse marks every conversion that lost information.

One operand can be accepted on every clock cycle while `inValid` is high. The result, flags and exception appear one cycle later, qualified by `outValid`. When no operand arrives, the result and flags keep their last values. The exception output stays low in those cycles.

Top module: `js_int32_convert`

## Requirements
- R1: An operand sampled with `inValid` high at a rising edge produces `outValid` high after that edge, for exactly one cycle per operand. Back-to-back operands give back-to-back results. With `inValid` low, `outValid` is low after the next edge.
- R2: Rounding is always toward zero. For example, 1.5 gives 1, -1.5 gives 0xFFFFFFFF and 0.5 gives 0.
- R3: With unbiased exponent e in 0..52, the magnitude is the 53-bit significand (implicit one included) shifted right by 52-e. With e in 53..115, it is the significand shifted left by e-52. With e of 116 or more, it is 0. In each case only the low 32 bits are kept, so the largest finite double gives 0.
- R4: A negative input returns the 32-bit two's-complement negation of its magnitude. For example, -10.0 gives 0xFFFFFFF6.
- R5: The result is 0 for +0, -0, either infinity, every NaN (exponent field all ones, nonzero fraction, quiet or signalling), every subnormal and every value with e < 0.
- R6: The flag word is bit 3 N, bit 2 Z, bit 1 C and bit 0 V. Z is 1 only when the input is a finite integer in [-2^31, 2^31-1] other than -0. So +0 sets Z, -2^31 sets Z, and 2^31 clears Z.
- R7: N, C and V read 0 for every conversion.
- R8: `outException` is high, only together with `outValid`, for NaN, infinity, a nonzero fraction (subnormals and magnitudes below one included) or a truncated integer outside the int32 range. It is low for exact conversions and for -0.
- R9: A synchronous active-high reset clears `outValid`, `outException`, the result and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Qualifies `inOperand` this cycle |
| inOperand | input | 64 | Double-precision bit pattern |
| outValid | output | 1 | Result strobe, one cycle per operand |
| outResult | output | 32 | Truncated, wrapped int32 result |
| outFlags | output | 4 | Condition word {N, Z, C, V} |
| outException | output | 1 | Inexact, out-of-range or non-finite input |

## Verification
The block has a single register stage. The result, flags and exception of each operand are therefore due on the first rising edge after it is presented, and on no other edge. The driver presents each operand half a cycle ahead of the capturing edge and queues the expected item. The monitor samples at the falling edge that follows. It pops one queued item for each `outValid` it sees, so a result that arrives early, late, twice or not at all shows up as a miscompare or as a leftover queue entry. Between results the monitor also checks that the exception stays low.

// File: rtl/conv_pkg.sv
package conv_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // register a new conversion
    logic idle;      // no operand this cycle: drop the exception pulse
  } conv_strobe_t;

  // condition word, N in the top bit
  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } cond_flags_t;

endpackage

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import conv_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output conv_strobe_t strobes,
  output logic         validQ
);

  always_comb begin
    strobes.capture = inValid;
    strobes.idle    = ~inValid;
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= inValid;
  end

  // R1: strobe follows the accepted operand by exactly one edge
  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
    inValid |=> validQ);
  assert_valid_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !validQ);
  // R9: reset empties the output stage
  assert_reset_valid_R9: assert property (@(posedge clk)
    rst |=> !validQ);

endmodule

// File: rtl/conv_datapath.sv
module conv_datapath
  import conv_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int OUT_W  = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  conv_strobe_t                 strobes,
  input  logic [EXP_W+FRAC_W:0]        operand,
  output logic [OUT_W-1:0]             resultQ,
  output cond_flags_t                  flagsQ,
  output logic                         excQ
);

  localparam int SIG_W   = FRAC_W + 1;
  localparam int EXPS_W  = EXP_W + 2;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_ALL = (1 << EXP_W) - 1;
  localparam int SH_W    = $clog2(SIG_W + OUT_W + 1);

  logic                    signBit;
  logic [EXP_W-1:0]        expField;
  logic [FRAC_W-1:0]       fracField;
  logic                    fracNz;
  logic                    isZero, isSub, isInf, isNan, isNorm;
  logic signed [EXPS_W-1:0] expUnb;
  logic [SIG_W-1:0]        sig;
  logic [SIG_W-1:0]        sigShr;
  logic [SIG_W-1:0]        lostMask;
  logic [OUT_W-1:0]        sigLow;
  logic [SH_W-1:0]         rightSh;
  logic [SH_W-1:0]         leftSh;
  logic                    expNeg, expRight, expLeft;
  logic [OUT_W-1:0]        magnitude;
  logic [OUT_W-1:0]        signedRes;
  logic                    lostBits;
  logic                    outOfRange;
  logic                    minIntCase;
  logic                    exact;
  logic                    raiseExc;

  // classification
  always_comb begin
    signBit   = operand[EXP_W+FRAC_W];
    expField  = operand[EXP_W+FRAC_W-1:FRAC_W];
    fracField = operand[FRAC_W-1:0];
    fracNz    = |fracField;
    isZero    = (expField == '0) && !fracNz;
    isSub     = (expField == '0) && fracNz;
    isInf     = (expField == EXP_W'(EXP_ALL)) && !fracNz;
    isNan     = (expField == EXP_W'(EXP_ALL)) && fracNz;
    isNorm    = (expField != '0) && (expField != EXP_W'(EXP_ALL));
    expUnb    = $signed({2'b00, expField}) - EXPS_W'(BIAS);
    sig       = {1'b1, fracField};
  end

  // integer extraction by shifting
  always_comb begin
    expNeg   = expUnb < 0;
    expRight = !expNeg && (expUnb <= EXPS_W'(FRAC_W));
    expLeft  = (expUnb > EXPS_W'(FRAC_W)) && (expUnb < EXPS_W'(FRAC_W + OUT_W));
    rightSh  = '0;
    leftSh   = '0;
    if (expRight) rightSh = SH_W'(EXPS_W'(FRAC_W) - expUnb);
    if (expLeft)  leftSh  = SH_W'(expUnb - EXPS_W'(FRAC_W));
    sigShr   = sig >> rightSh;
    lostMask = (SIG_W'(1) << rightSh) - SIG_W'(1);
    sigLow   = sig[OUT_W-1:0];
    if (expRight)     magnitude = sigShr[OUT_W-1:0];
    else if (expLeft) magnitude = sigLow << leftSh;
    else              magnitude = '0;
    if (expNeg)        lostBits = 1'b1;
    else if (expRight) lostBits = |(sig & lostMask);
    else               lostBits = 1'b0;
  end

  // sign, range and exactness
  always_comb begin
    signedRes  = signBit ? (~magnitude + OUT_W'(1)) : magnitude;
    minIntCase = signBit && (expUnb == EXPS_W'(OUT_W - 1)) && !fracNz;
    outOfRange = (expUnb >= EXPS_W'(OUT_W - 1)) && !minIntCase;
    exact      = (isZero && !signBit) || (isNorm && !lostBits && !outOfRange);
    raiseExc   = isNan || isInf || isSub || (isNorm && (lostBits || outOfRange));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultQ <= '0;
      flagsQ  <= '0;
      excQ    <= 1'b0;
    end else begin
      if (strobes.capture) begin
        resultQ  <= isNorm ? signedRes : '0;
        flagsQ.n <= 1'b0;
        flagsQ.z <= exact;
        flagsQ.c <= 1'b0;
        flagsQ.v <= 1'b0;
        excQ     <= raiseExc;
      end
      if (strobes.idle) excQ <= 1'b0;
    end
  end

  // R5: non-finite input yields a zero word
  assert_nonfinite_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && (isNan || isInf)) |=> (resultQ == '0));
  // R6: an exact report never coexists with an exception
  assert_exact_noexc_R6: assert property (@(posedge clk) disable iff (rst)
    flagsQ.z |-> !excQ);
  // R7: the unused condition bits stay low
  assert_ncv_low_R7: assert property (@(posedge clk) disable iff (rst)
    (!flagsQ.n && !flagsQ.c && !flagsQ.v));
  // R8: a non-finite operand always raises the exception
  assert_nonfinite_exc_R8: assert property (@(posedge clk) disable iff (rst)
    (strobes.capture && (isNan || isInf)) |=> excQ);
  // R9: reset clears the stored result and flags
  assert_reset_data_R9: assert property (@(posedge clk)
    rst |=> (resultQ == '0 && flagsQ == '0 && !excQ));

endmodule

// File: rtl/js_int32_convert.sv
module js_int32_convert
  import conv_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52,
  parameter int OUT_W  = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] inOperand,
  output logic                  outValid,
  output logic [OUT_W-1:0]      outResult,
  output logic [3:0]            outFlags,
  output logic                  outException
);

  conv_strobe_t strobes;
  cond_flags_t  flagsQ;

  conv_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobes (strobes),
    .validQ  (outValid)
  );

  conv_datapath #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W),
    .OUT_W  (OUT_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .operand (inOperand),
    .resultQ (outResult),
    .flagsQ  (flagsQ),
    .excQ    (outException)
  );

  assign outFlags = flagsQ;

  // R8: the exception is a pulse carried only by a valid result
  assert_exc_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    outException |-> outValid);

endmodule

// File: tb/js_int32_convert_tb.sv
module js_int32_convert_tb;

  typedef struct {
    logic [63:0] op;
    logic [31:0] res;
    logic        z;
    logic        exc;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [63:0] inOperand = '0;
  logic        outValid;
  logic [31:0] outResult;
  logic [3:0]  outFlags;
  logic        outException;

  int applied = 0;
  int fails = 0;
  bit done = 0;
  item_t expq[$];

  always #2.5 clk = ~clk;

  js_int32_convert u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inOperand(inOperand),
    .outValid(outValid), .outResult(outResult), .outFlags(outFlags),
    .outException(outException)
  );

  // reference model built on a wide integer, independent of the shift split
  function automatic item_t model(input logic [63:0] d);
    item_t it;
    logic s;
    int ex, e;
    logic [52:0] sig;
    logic [179:0] wide;
    logic [127:0] ip;
    logic fnz, big, inRange;
    logic [31:0] mag;
    it.op = d;
    s  = d[63];
    ex = int'(d[62:52]);
    big = 1'b0;
    if (ex == 2047) begin
      it.res = 0; it.z = 0; it.exc = 1;
    end else if (ex == 0 && d[51:0] == 0) begin
      it.res = 0; it.z = !s; it.exc = 0;
    end else begin
      e   = (ex == 0) ? -1022 : ex - 1023;
      sig = (ex == 0) ? {1'b0, d[51:0]} : {1'b1, d[51:0]};
      ip = '0; fnz = 1'b0;
      if (e < 0) begin
        fnz = 1'b1;
      end else if (e >= 127) begin
        big = 1'b1;
      end else begin
        wide = {127'b0, sig} << e;
        ip   = wide[179:52];
        fnz  = |wide[51:0];
      end
      inRange = !big && (s ? (ip <= 128'h8000_0000) : (ip <= 128'h7fff_ffff));
      mag = ip[31:0];
      it.res = s ? (32'd0 - mag) : mag;
      it.z   = !fnz && inRange;
      it.exc = fnz || !inRange;
    end
    return it;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    applied++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] d);
    @(negedge clk);
    inValid   = 1'b1;
    inOperand = d;
    expq.push_back(model(d));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inValid = 1'b0;
      inOperand = 64'hdead_beef_dead_beef;
    end
  endtask

  // monitor: compares at falling edges, results are due one edge after the operand
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (outValid) begin
        if (expq.size() == 0) begin
          check(0, "R1", "unexpected result", {63'b0, outValid}, 64'd0);
        end else begin
          item_t it;
          it = expq.pop_front();
          // R2 R3 R4 R5 result word
          check(outResult == it.res, "R2/R3/R4/R5", $sformatf("result for %h", it.op),
                {32'b0, outResult}, {32'b0, it.res});
          // R6 Z bit, R7 N C V low
          check(outFlags == {1'b0, it.z, 2'b00}, "R6/R7", $sformatf("flags for %h", it.op),
                {60'b0, outFlags}, {60'b0, 1'b0, it.z, 2'b00});
          // R8 exception
          check(outException == it.exc, "R8", $sformatf("exception for %h", it.op),
                {63'b0, outException}, {63'b0, it.exc});
        end
      end else if (outException) begin
        check(0, "R8", "exception without valid", 64'd1, 64'd0);
      end
    end
  end

  // watchdog
  initial begin
    #(5ns * 100000);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!outValid && outResult == 0 && outFlags == 0 && !outException, "R9",
          "reset state", {outValid, outException, outFlags, outResult},
          64'd0);
    @(negedge clk);
    rst = 1'b0;

    drive(64'h0000_0000_0000_0000); // +0: R6 Z set
    drive(64'h8000_0000_0000_0000); // -0: R6 Z clear, no exception
    drive(64'h3ff0_0000_0000_0000); // 1.0
    drive(64'hbff0_0000_0000_0000); // -1.0 R4
    drive(64'h3ff8_0000_0000_0000); // 1.5 R2
    drive(64'hbff8_0000_0000_0000); // -1.5 R2
    drive(64'h3fe0_0000_0000_0000); // 0.5 R2
    drive(64'h4024_0000_0000_0000); // 10
    drive(64'hc024_0000_0000_0000); // -10 R4
    drive(64'h7fef_ffff_ffff_ffff); // max finite R3
    drive(64'h7ff0_0000_0000_0000); // +inf R5
    drive(64'hfff0_0000_0000_0000); // -inf R5
    drive(64'h7ff8_0000_0000_0000); // qNaN R5
    drive(64'h7ff1_2345_6789_abcd); // sNaN R5
    drive(64'h0001_2345_6789_abcd); // subnormal R5
    drive(64'h0010_0000_0000_0000); // smallest normal R5
    drive(64'h41e0_0000_0000_0000); // 2^31 out of range R6
    drive(64'hc1e0_0000_0000_0000); // -2^31 exact R6
    drive(64'h41df_ffff_ffc0_0000); // 2^31-1 exact R6
    drive(64'h41f0_0000_0050_0000); // 2^32+5 wraps R3
    idle(1);
    // R1: no operand, no strobe
    @(negedge clk);
    check(!outValid, "R1", "strobe after idle cycle", {63'b0, outValid}, 64'd0);

    // R3 R4: every exponent, both signs, with idle gaps
    for (int ex = 0; ex < 2048; ex++) begin
      logic [63:0] v;
      v = {1'b0, 11'(ex), 52'h1_2345_6789_0abc};
      drive(v);
      drive(v | 64'h8000_0000_0000_0000);
      if (ex % 97 == 0) idle(2);
    end
    idle(3);
    check(expq.size() == 0, "R1", "results outstanding", 64'(expq.size()), 64'd0);

    // R9: reset mid-stream clears outputs
    drive(64'hc024_0000_0000_0000);
    @(negedge clk);
    inValid = 1'b0;
    rst = 1'b1;
    expq.delete();
    @(negedge clk);
    check(!outValid && outResult == 0 && outFlags == 0 && !outException, "R9",
          "reset clears outputs", {outValid, outException, outFlags, outResult}, 64'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, fails);
    $finish;
  end

endmodule